// File: doc/BRIEF.md
# Privilege-Filtered Cycle Counter

This block keeps a 64-bit machine cycle counter. It also keeps a 64-bit configuration register that can stop the count while the hart runs in chosen privilege modes. The current privilege level and a virtualization flag arrive as inputs every cycle. The counter advances by one on each clock edge unless one of two things holds: a whole-counter inhibit input is high, or the inhibit bit for the current mode is set. Turning an inhibit bit on or off changes the count from the next clock edge.

A CSR port serves both registers:

- The configuration register is at 0x321.
- The counter is at 0xB00.
- On a 32-bit build, the upper halves are at 0x721 and 0xB80.

Only five inhibit bits hold state. Every other configuration bit reads as zero. An access from below machine mode raises an illegal flag and changes nothing. The same happens for an access to an address the build does not decode.

Top module: `pfc_cycle_csr`

## Requirements
- R1: While reset is held, the counter output is zero and every inhibit bit is clear. A read of 0x321 or 0x721 then returns zero.
- R2: When every inhibit bit is clear and the whole-counter inhibit input is low, the counter grows by exactly one per clock in every privilege mode.
- R3: Modes are decoded as follows:
  - priv[1]=1 is machine mode, whatever the virtualization flag. This covers 2'b11 and the reserved 2'b10.
  - priv=01 with virt=0 is S.
  - priv=00 with virt=0 is U.
  - priv=01 with virt=1 is VS.
  - priv=00 with virt=1 is VU.

  Configuration bits 62, 61, 60, 59 and 58 inhibit M, S, U, VS and VU respectively. A set bit freezes the counter only in its own mode.
- R4: A high whole-counter inhibit input freezes the counter in every mode, whatever the configuration.
- R5: Configuration bit 63 and bits 57:0 always read as zero, and writes to them have no effect.
- R6: On XLEN=32, 0x321 reaches configuration bits 31:0 and 0x721 reaches bits 63:32. On XLEN=64, 0x321 reaches all 64 bits, and 0x721 and 0xB80 are illegal.
- R7: Some inhibit bits read as zero and ignore writes, because their mode is absent:
  - S when HAS_S=0.
  - U when HAS_U=0.
  - VS when HAS_H=0 or HAS_S=0.
  - VU when HAS_H=0 or HAS_U=0.
- R8: The counter is read and written at 0xB00 (the low half on XLEN=32, the whole counter on XLEN=64) and at 0xB80 (the high half on XLEN=32).
  - A half write keeps the other half.
  - A write replaces that cycle's increment, so the written value is visible after the next edge.
  - Counting resumes from the written value.
- R9: The illegal flag is raised, the read data is zero and no register changes in two cases:
  - an access made while priv is not 2'b11;
  - an access to an address outside the decoded set.
- R10: With HAS_FILTER=0, both configuration addresses are illegal and the counter is never filtered by mode. The counter addresses stay legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level (00 U, 01 S, 11 M) |
| virt_i | input | 1 | Virtualization flag; with priv 01/00 selects VS/VU |
| cnt_inhibit_i | input | 1 | Whole-counter inhibit |
| csr_en_i | input | 1 | CSR access valid this cycle |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_illegal_o | output | 1 | Illegal-access flag (combinational) |
| cycle_o | output | 64 | Current counter value |

## Verification
The bench builds three instances, each reaching behaviour the others cannot:

- A 32-bit instance with every mode present. It is used to sweep all five mode decodes and the half-register addressing, including the carry from the low counter half into the high half.
- A 64-bit instance without S-mode or hypervisor support. It shows that the S, VS and VU inhibit bits stay hardwired to zero, that the full-width configuration and counter accesses work, and that the high-half addresses are rejected.
- A 32-bit instance with HAS_FILTER=0. It shows that both configuration addresses become illegal while counting carries on unfiltered.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [2:0] {
    MODE_U  = 3'd0,
    MODE_S  = 3'd1,
    MODE_M  = 3'd2,
    MODE_VS = 3'd3,
    MODE_VU = 3'd4
  } pmode_e;

  localparam logic [11:0] ADDR_CFG  = 12'h321;
  localparam logic [11:0] ADDR_CFGH = 12'h721;
  localparam logic [11:0] ADDR_CYC  = 12'hB00;
  localparam logic [11:0] ADDR_CYCH = 12'hB80;

  localparam logic [1:0] PRIV_M = 2'b11;

  // Inhibit field sits in configuration bits 62 (M) down to 58 (VU).
  localparam int INH_TOP = 62;
  localparam int INH_LOW = 58;
  localparam int NMODES  = INH_TOP - INH_LOW + 1;

  function automatic pmode_e decode_mode(input logic [1:0] priv, input logic virt);
    if (priv[1])      return MODE_M;
    else if (virt)    return priv[0] ? MODE_VS : MODE_VU;
    else              return priv[0] ? MODE_S  : MODE_U;
  endfunction

  // Bit order matches the field: [4]=M, [3]=S, [2]=U, [1]=VS, [0]=VU.
  function automatic logic [NMODES-1:0] mode_onehot(input pmode_e m);
    case (m)
      MODE_M:  return 5'b10000;
      MODE_S:  return 5'b01000;
      MODE_U:  return 5'b00100;
      MODE_VS: return 5'b00010;
      default: return 5'b00001;
    endcase
  endfunction

  function automatic logic [NMODES-1:0] impl_mask(input bit has_s, input bit has_u,
                                                  input bit has_h);
    return {1'b1, has_s, has_u, has_h & has_s, has_h & has_u};
  endfunction

  function automatic logic [63:0] cfg_image(input logic [NMODES-1:0] inh);
    logic [63:0] img;
    img = '0;
    img[INH_TOP:INH_LOW] = inh;
    return img;
  endfunction

endpackage

// File: rtl/pfc_csr_decode.sv
module pfc_csr_decode
  import pfc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic        en_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  output logic        sel_cfg_lo_o,
  output logic        sel_cfg_hi_o,
  output logic        sel_cyc_lo_o,
  output logic        sel_cyc_hi_o,
  output logic        illegal_o,
  output logic        cfg_we_lo_o,
  output logic        cfg_we_hi_o,
  output logic        cyc_we_lo_o,
  output logic        cyc_we_hi_o
);

  localparam bit HALVES = (XLEN == 32);

  logic hit_cfg_lo, hit_cfg_hi, hit_cyc_lo, hit_cyc_hi;
  logic known, priv_ok, grant;

  always_comb begin
    hit_cfg_lo = HAS_FILTER && (addr_i == ADDR_CFG);
    hit_cfg_hi = HAS_FILTER && HALVES && (addr_i == ADDR_CFGH);
    hit_cyc_lo = (addr_i == ADDR_CYC);
    hit_cyc_hi = HALVES && (addr_i == ADDR_CYCH);
    known      = hit_cfg_lo | hit_cfg_hi | hit_cyc_lo | hit_cyc_hi;
    priv_ok    = (priv_i == PRIV_M);
    grant      = en_i && known && priv_ok;
    illegal_o  = en_i && !(known && priv_ok);
  end

  assign sel_cfg_lo_o = grant && hit_cfg_lo;
  assign sel_cfg_hi_o = grant && hit_cfg_hi;
  assign sel_cyc_lo_o = grant && hit_cyc_lo;
  assign sel_cyc_hi_o = grant && hit_cyc_hi;
  assign cfg_we_lo_o  = sel_cfg_lo_o && we_i;
  assign cfg_we_hi_o  = sel_cfg_hi_o && we_i;
  assign cyc_we_lo_o  = sel_cyc_lo_o && we_i;
  assign cyc_we_hi_o  = sel_cyc_hi_o && we_i;

endmodule

// File: rtl/pfc_mode_filter.sv
module pfc_mode_filter
  import pfc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_FILTER = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_H      = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              global_inh_i,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [NMODES-1:0] inh_o,
  output logic [63:0]       cfg_o,
  output logic              tick_o
);

  localparam logic [NMODES-1:0] IMPL = impl_mask(HAS_S, HAS_U, HAS_H);

  logic [NMODES-1:0] inh_q;

  generate
    if (HAS_FILTER) begin : g_cfg
      logic [63:0]       merged;
      logic [NMODES-1:0] inh_d;

      always_comb begin
        merged = cfg_image(inh_q);
        if (we_lo_i) merged[XLEN-1:0] = wdata_i;
        if (we_hi_i) merged[63:32]    = wdata_i[31:0];
        inh_d = merged[INH_TOP:INH_LOW] & IMPL;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) inh_q <= '0;
        else         inh_q <= inh_d;
      end
    end else begin : g_nocfg
      logic unused_nocfg;
      assign unused_nocfg = ^{clk_i, rst_ni, we_lo_i, we_hi_i, wdata_i};
      assign inh_q = '0;
    end
  endgenerate

  pmode_e mode;
  assign mode   = decode_mode(priv_i, virt_i);
  assign inh_o  = inh_q;
  assign cfg_o  = cfg_image(inh_q);
  assign tick_o = !global_inh_i && ((mode_onehot(mode) & inh_q) == '0);

endmodule

// File: rtl/pfc_counter.sv
module pfc_counter #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            we_lo_i,
  input  logic            we_hi_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [63:0]     cycle_o,
  output logic            wr_o,
  output logic [63:0]     wval_o
);

  logic [63:0] cyc_q, cyc_d;

  always_comb begin
    wval_o = cyc_q;
    if (we_lo_i) wval_o[XLEN-1:0] = wdata_i;
    if (we_hi_i) wval_o[63:32]    = wdata_i[31:0];
    wr_o  = we_lo_i | we_hi_i;
    cyc_d = wr_o ? wval_o : cyc_q + {63'd0, tick_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_d;
  end

  assign cycle_o = cyc_q;

endmodule

// File: rtl/pfc_cycle_csr.sv
module pfc_cycle_csr
  import pfc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_FILTER = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_H      = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            cnt_inhibit_i,
  input  logic            csr_en_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic [63:0]     cycle_o
);

  logic sel_cfg_lo, sel_cfg_hi, sel_cyc_lo, sel_cyc_hi;
  logic cfg_we_lo, cfg_we_hi, cyc_we_lo, cyc_we_hi;
  logic illegal;
  logic tick;
  logic cnt_wr;
  logic [63:0] cnt_wval;
  logic [63:0] cfg_img;
  logic [NMODES-1:0] inh;

  pfc_csr_decode #(.XLEN(XLEN), .HAS_FILTER(HAS_FILTER)) u_dec (
    .en_i(csr_en_i), .we_i(csr_we_i), .addr_i(csr_addr_i), .priv_i(priv_i),
    .sel_cfg_lo_o(sel_cfg_lo), .sel_cfg_hi_o(sel_cfg_hi),
    .sel_cyc_lo_o(sel_cyc_lo), .sel_cyc_hi_o(sel_cyc_hi),
    .illegal_o(illegal),
    .cfg_we_lo_o(cfg_we_lo), .cfg_we_hi_o(cfg_we_hi),
    .cyc_we_lo_o(cyc_we_lo), .cyc_we_hi_o(cyc_we_hi)
  );

  pfc_mode_filter #(
    .XLEN(XLEN), .HAS_FILTER(HAS_FILTER),
    .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H)
  ) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .priv_i(priv_i), .virt_i(virt_i),
    .global_inh_i(cnt_inhibit_i), .we_lo_i(cfg_we_lo), .we_hi_i(cfg_we_hi),
    .wdata_i(csr_wdata_i), .inh_o(inh), .cfg_o(cfg_img), .tick_o(tick)
  );

  pfc_counter #(.XLEN(XLEN)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .we_lo_i(cyc_we_lo), .we_hi_i(cyc_we_hi), .wdata_i(csr_wdata_i),
    .cycle_o(cycle_o), .wr_o(cnt_wr), .wval_o(cnt_wval)
  );

  logic [63:0] rd_full;
  always_comb begin
    rd_full = '0;
    if (sel_cfg_lo)      rd_full = cfg_img;
    else if (sel_cfg_hi) rd_full = {32'd0, cfg_img[63:32]};
    else if (sel_cyc_lo) rd_full = cycle_o;
    else if (sel_cyc_hi) rd_full = {32'd0, cycle_o[63:32]};
  end

  logic unused_rd;
  assign unused_rd = ^rd_full;

  assign csr_rdata_o   = rd_full[XLEN-1:0];
  assign csr_illegal_o = illegal;

endmodule

// File: rtl/pfc_cycle_csr_chk.sv
module pfc_cycle_csr_chk
  import pfc_pkg::*;
#(
  parameter bit HAS_FILTER = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_H      = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        priv_i,
  input logic              cnt_inhibit_i,
  input logic              csr_en_i,
  input logic              illegal,
  input logic              tick,
  input logic              cnt_wr,
  input logic [63:0]       cnt_wval,
  input logic [63:0]       cycle_o,
  input logic [63:0]       cfg_img,
  input logic [NMODES-1:0] inh,
  input logic              cfg_we_lo,
  input logic              cfg_we_hi
);

  localparam logic [NMODES-1:0] LIVE = HAS_FILTER ? impl_mask(HAS_S, HAS_U, HAS_H) : '0;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr) |=> (cycle_o == $past(cycle_o) + 64'd1));

  assert_frozen_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !cnt_wr) |=> $stable(cycle_o));

  assert_mode_m_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i[1] && inh[4]) |-> !tick);

  assert_global_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_inhibit_i |-> !tick);

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_img[63] == 1'b0) && (cfg_img[57:0] == 58'd0));

  assert_absent_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh & ~LIVE) == '0);

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cycle_o == $past(cnt_wval)));

  assert_low_priv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && priv_i != PRIV_M) |-> illegal);

  assert_no_side_effect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |-> (!cnt_wr && !cfg_we_lo && !cfg_we_hi));

endmodule

bind pfc_cycle_csr pfc_cycle_csr_chk #(
  .HAS_FILTER(HAS_FILTER), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .priv_i(priv_i), .cnt_inhibit_i(cnt_inhibit_i),
  .csr_en_i(csr_en_i), .illegal(illegal), .tick(tick), .cnt_wr(cnt_wr),
  .cnt_wval(cnt_wval), .cycle_o(cycle_o), .cfg_img(cfg_img), .inh(inh),
  .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi)
);

// File: tb/pfc_cycle_csr_tb.sv
module pfc_cycle_csr_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  priv = 2'b11;
  logic        virt = 1'b0;
  logic        ginh = 1'b0;
  logic        en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;

  logic [31:0] rd_a, rd_c;
  logic [63:0] rd_b;
  logic        ill_a, ill_b, ill_c;
  logic [63:0] cyc_a, cyc_b, cyc_c;

  pfc_cycle_csr #(.XLEN(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .priv_i(priv), .virt_i(virt), .cnt_inhibit_i(ginh),
    .csr_en_i(en_a), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata[31:0]),
    .csr_rdata_o(rd_a), .csr_illegal_o(ill_a), .cycle_o(cyc_a));

  pfc_cycle_csr #(.XLEN(64), .HAS_S(1'b0), .HAS_H(1'b0)) u_dut64 (
    .clk_i(clk), .rst_ni(rst_ni), .priv_i(priv), .virt_i(virt), .cnt_inhibit_i(ginh),
    .csr_en_i(en_b), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_rdata_o(rd_b), .csr_illegal_o(ill_b), .cycle_o(cyc_b));

  pfc_cycle_csr #(.XLEN(32), .HAS_FILTER(1'b0)) u_dut_nf (
    .clk_i(clk), .rst_ni(rst_ni), .priv_i(priv), .virt_i(virt), .cnt_inhibit_i(ginh),
    .csr_en_i(en_c), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata[31:0]),
    .csr_rdata_o(rd_c), .csr_illegal_o(ill_c), .cycle_o(cyc_c));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_en(input int which, input logic v);
    en_a = (which == 0) ? v : 1'b0;
    en_b = (which == 1) ? v : 1'b0;
    en_c = (which == 2) ? v : 1'b0;
  endtask

  // Write across one posedge; returns at the following negedge.
  task automatic wr(input int which, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; set_en(which, 1'b1);
    @(negedge clk);
    we = 1'b0; set_en(which, 1'b0);
  endtask

  // Combinational read mid-cycle.
  task automatic rd(input int which, input logic [11:0] a,
                    output logic [63:0] val, output logic ill);
    addr = a; we = 1'b0; set_en(which, 1'b1);
    #1;
    case (which)
      0:       begin val = {32'd0, rd_a}; ill = ill_a; end
      1:       begin val = rd_b;          ill = ill_b; end
      default: begin val = {32'd0, rd_c}; ill = ill_c; end
    endcase
    set_en(which, 1'b0);
  endtask

  // {priv[2], virt[1], cfg high word[32], expected delta over 4 cycles[4]}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {2'd3, 1'b0, 32'h0000_0000, 4'd4},
    {2'd3, 1'b0, 32'h4000_0000, 4'd0},
    {2'd1, 1'b0, 32'h4000_0000, 4'd4},
    {2'd1, 1'b0, 32'h2000_0000, 4'd0},
    {2'd0, 1'b0, 32'h2000_0000, 4'd4},
    {2'd0, 1'b0, 32'h1000_0000, 4'd0},
    {2'd1, 1'b1, 32'h1000_0000, 4'd4},
    {2'd1, 1'b1, 32'h0800_0000, 4'd0},
    {2'd0, 1'b1, 32'h0800_0000, 4'd4},
    {2'd0, 1'b1, 32'h0400_0000, 4'd0},
    {2'd3, 1'b1, 32'h0400_0000, 4'd4},
    {2'd3, 1'b1, 32'h4000_0000, 4'd0},
    {2'd2, 1'b0, 32'h4000_0000, 4'd0},
    {2'd0, 1'b0, 32'h7C00_0000, 4'd0},
    {2'd1, 1'b1, 32'hFFFF_FFFF, 4'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, c0, h0;
    logic        il;
    logic [31:0] lo;

    // R1: state under reset
    #5;
    chk("R1 counter under reset", cyc_a, 64'd0);
    rd(0, 12'h321, v, il); chk("R1 cfg low under reset", v, 64'd0);
    rd(0, 12'h721, v, il); chk("R1 cfg high under reset", v, 64'd0);
    repeat (3) @(negedge clk);
    chk("R1 counter still zero", cyc_a, 64'd0);
    rst_ni = 1'b1;

    // R2/R3: mode table sweep on the 32-bit instance
    for (int i = 0; i < NV; i++) begin
      logic [38:0] e;
      e = VEC[i];
      priv = 2'b11; virt = 1'b0;
      wr(0, 12'h721, {32'd0, e[35:4]});
      rd(0, 12'h721, v, il);
      chk("R5 cfg high readback masks reserved", v, {32'd0, e[35:4] & 32'h7C00_0000});
      priv = e[38:37]; virt = e[36];
      c0 = cyc_a;
      repeat (4) @(negedge clk);
      chk($sformatf("R3 R2 vector %0d count delta", i), cyc_a - c0, {60'd0, e[3:0]});
    end

    priv = 2'b11; virt = 1'b0;
    wr(0, 12'h721, 64'd0);

    // R4: whole-counter inhibit
    ginh = 1'b1;
    c0 = cyc_a;
    repeat (4) @(negedge clk);
    chk("R4 global inhibit freezes", cyc_a - c0, 64'd0);
    ginh = 1'b0;

    // R5: low-half writes ignored
    wr(0, 12'h321, 64'hFFFF_FFFF);
    rd(0, 12'h321, v, il); chk("R5 cfg low reads zero", v, 64'd0);
    rd(0, 12'h721, v, il); chk("R5 cfg high untouched", v, 64'd0);

    // R8: counter halves, write priority, carry
    h0 = {32'd0, cyc_a[63:32]};
    wr(0, 12'hB00, 64'hFFFF_FFF0);
    chk("R8 low write replaces increment", cyc_a, {h0[31:0], 32'hFFFF_FFF0});
    repeat (20) @(negedge clk);
    chk("R8 carry into high half", cyc_a, {h0[31:0] + 32'd1, 32'h0000_0004});
    rd(0, 12'hB00, v, il);
    chk("R8 low half CSR read", v, {32'd0, cyc_a[31:0]});
    @(negedge clk);
    lo = cyc_a[31:0];
    addr = 12'hB80; wdata = 64'h1234_5678; we = 1'b1; en_a = 1'b1;
    @(negedge clk);
    we = 1'b0; en_a = 1'b0;
    chk("R8 high write keeps low half", cyc_a, {32'h1234_5678, lo});
    rd(0, 12'hB80, v, il);
    chk("R8 high half CSR read", v, 64'h1234_5678);

    // R9: low privilege and unknown address
    priv = 2'b01;
    c0 = cyc_a;
    addr = 12'hB00; wdata = 64'd0; we = 1'b1; en_a = 1'b1;
    #1;
    chk("R9 S-mode access illegal", {63'd0, ill_a}, 64'd1);
    chk("R9 illegal read data zero", {32'd0, rd_a}, 64'd0);
    @(negedge clk);
    we = 1'b0; en_a = 1'b0;
    chk("R9 rejected write leaves counter counting", cyc_a, c0 + 64'd1);
    priv = 2'b00;
    wr(0, 12'h721, 64'h7C00_0000);
    priv = 2'b11;
    rd(0, 12'h721, v, il);
    chk("R9 rejected cfg write no change", v, 64'd0);
    rd(0, 12'h322, v, il);
    chk("R9 unknown address illegal", {63'd0, il}, 64'd1);
    rd(0, 12'h721, v, il);
    chk("R9 legal machine read not illegal", {63'd0, il}, 64'd0);

    // R6/R7: 64-bit instance without S and hypervisor
    wr(1, 12'h321, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1, 12'h321, v, il);
    chk("R7 R6 absent bits hardwired, full width", v, 64'h5000_0000_0000_0000);
    rd(1, 12'h721, v, il);
    chk("R6 high cfg address illegal on 64-bit", {63'd0, il}, 64'd1);
    rd(1, 12'hB80, v, il);
    chk("R6 high counter address illegal on 64-bit", {63'd0, il}, 64'd1);
    wr(1, 12'hB00, 64'h0123_4567_89AB_CDEF);
    chk("R8 full-width counter write", cyc_b, 64'h0123_4567_89AB_CDEF);
    repeat (3) @(negedge clk);
    chk("R3 M inhibited on 64-bit", cyc_b, 64'h0123_4567_89AB_CDEF);
    priv = 2'b00;
    repeat (3) @(negedge clk);
    chk("R3 U inhibited on 64-bit", cyc_b, 64'h0123_4567_89AB_CDEF);
    priv = 2'b01; c0 = cyc_b;
    repeat (4) @(negedge clk);
    chk("R7 S bit absent so S counts", cyc_b - c0, 64'd4);
    virt = 1'b1; c0 = cyc_b;
    repeat (4) @(negedge clk);
    chk("R7 VS bit absent so VS counts", cyc_b - c0, 64'd4);
    priv = 2'b00; c0 = cyc_b;
    repeat (4) @(negedge clk);
    chk("R7 VU bit absent so VU counts", cyc_b - c0, 64'd4);
    priv = 2'b11; virt = 1'b0;

    // R10: filter parameterized out
    rd(2, 12'h321, v, il);
    chk("R10 cfg low illegal without filter", {63'd0, il}, 64'd1);
    rd(2, 12'h721, v, il);
    chk("R10 cfg high illegal without filter", {63'd0, il}, 64'd1);
    rd(2, 12'hB00, v, il);
    chk("R10 counter address still legal", {63'd0, il}, 64'd0);
    c0 = cyc_c;
    repeat (4) @(negedge clk);
    chk("R10 counts unfiltered", cyc_c - c0, 64'd4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule